// File: doc/BRIEF.md
# Digital Rheostat Wiper Control Register

This block holds the 8-bit position code of a 256-tap resistor ladder and produces the digital controls for that ladder. The codes it handles run from the bottom terminal upward: code 0x00 puts the wiper on the tap at the low (B) end. Each higher code moves the wiper one tap toward the high (A) end, and code 0xFF stops one step short of it. A serial interface block decodes the bus traffic and passes it in as two single-cycle strobes. The command strobe carries the midscale-reset and shutdown levels of an instruction byte. The data strobe carries a new position byte.

Shutdown opens the high terminal and ties the wiper to the low terminal, but it keeps the stored code. Writes that arrive during shutdown are stored. When shutdown ends, the most recent stored code reaches the ladder. Midscale reset is different: it really overwrites the stored code with 0x80. The readback output always shows the stored code.

Top module: `wiper_ctrl`

## Requirements
- R1: A synchronous reset sets the stored code to 0x80 and clears shutdown. After the reset, tap_code and rd_value read 0x80, and open_a and short_wb read 0.
- R2: A data strobe without a midscale command loads data_in into the stored code. The new value shows on rd_value right after the clock edge that samples the strobe.
- R3: A command strobe with mid_rst=1 loads the stored code with 0x80. The code stays 0x80 after later commands with mid_rst=0, until new data is written.
- R4: A command strobe copies shut_req into the shutdown state. open_a and short_wb are both 1 exactly while the state is set.
- R5: While shut down, tap_code is 0x00 (wiper at the low end), and the stored code is not changed by the shutdown itself.
- R6: A data write made during shutdown is stored. When shutdown is cleared, tap_code shows the last code written.
- R7: A command with mid_rst=1 and shut_req=1 loads 0x80 and enters shutdown in the same edge.
- R8: rd_value always equals the stored code, in or out of shutdown.
- R9: In a cycle with no strobe, data_in, mid_rst and shut_req have no effect. All outputs hold their values.
- R10: If the command strobe with mid_rst=1 and the data strobe come in the same cycle, the stored code becomes 0x80. The data byte is dropped.
- R11: Out of shutdown, tap_code equals the stored code for every value from 0x00 to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_stb | input | 1 | One-cycle strobe: an instruction byte has been decoded |
| mid_rst | input | 1 | Midscale-reset level of the instruction |
| shut_req | input | 1 | Shutdown level of the instruction |
| data_stb | input | 1 | One-cycle strobe: a position byte has been received |
| data_in | input | 8 | Position byte |
| tap_code | output | 8 | Tap select code driven to the ladder decoder |
| open_a | output | 1 | Open the high-end terminal switch |
| short_wb | output | 1 | Short the wiper to the low-end terminal |
| rd_value | output | 8 | Stored code for readback |

## Verification
The checker applies several rules on every cycle:
- the reset and midscale loads give 0x80;
- data writes land one edge after their strobe;
- both terminal controls track the last shutdown command;
- tap_code is 0x00 in shutdown and equals the stored code outside it;
- outputs hold when no strobe arrives.

Some orderings only the bench scenarios can show. One is a chain of writes made during shutdown where only the last one surfaces on exit. Another is a midscale value that persists across later commands. A third is the collision of midscale reset with a data strobe. The bench also runs a sweep of the ends and the middle of the code range.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
    parameter int CODE_W = 8;
    localparam int TAPS = 1 << CODE_W;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic mid;
        logic shut;
    } instr_t;

    typedef struct packed {
        code_t tap;
        logic  open_hi;
        logic  tie_lo;
    } ladder_t;

    function automatic code_t midscale();
        return code_t'(TAPS / 2);
    endfunction

    function automatic code_t bottom();
        return '0;
    endfunction
endpackage

// File: rtl/wiper_store.sv
module wiper_store
    import wiper_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cmd_stb,
    input  instr_t instr,
    input  logic   data_stb,
    input  code_t  data_in,
    output code_t  code_q
);
    logic  load_mid;
    code_t code_d;

    assign load_mid = cmd_stb && instr.mid;

    always_comb begin
        code_d = code_q;
        if (load_mid)
            code_d = midscale();
        else if (data_stb)
            code_d = data_in;
    end

    always_ff @(posedge clk) begin
        if (rst)
            code_q <= midscale();
        else
            code_q <= code_d;
    end
endmodule

// File: rtl/wiper_mode.sv
module wiper_mode
    import wiper_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cmd_stb,
    input  instr_t instr,
    output logic   shut_q
);
    always_ff @(posedge clk) begin
        if (rst)
            shut_q <= 1'b0;
        else if (cmd_stb)
            shut_q <= instr.shut;
    end
endmodule

// File: rtl/wiper_drive.sv
module wiper_drive
    import wiper_pkg::*;
(
    input  code_t   code_q,
    input  logic    shut_q,
    output ladder_t ladder
);
    always_comb begin
        ladder.open_hi = shut_q;
        ladder.tie_lo  = shut_q;
        ladder.tap     = shut_q ? bottom() : code_q;
    end
endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
    import wiper_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_stb,
    input  logic              mid_rst,
    input  logic              shut_req,
    input  logic              data_stb,
    input  logic [CODE_W-1:0] data_in,
    output logic [CODE_W-1:0] tap_code,
    output logic              open_a,
    output logic              short_wb,
    output logic [CODE_W-1:0] rd_value
);
    instr_t  instr;
    code_t   code_q;
    logic    shut_q;
    ladder_t ladder;

    assign instr.mid  = mid_rst;
    assign instr.shut = shut_req;

    wiper_store u_store (
        .clk      (clk),
        .rst      (rst),
        .cmd_stb  (cmd_stb),
        .instr    (instr),
        .data_stb (data_stb),
        .data_in  (data_in),
        .code_q   (code_q)
    );

    wiper_mode u_mode (
        .clk     (clk),
        .rst     (rst),
        .cmd_stb (cmd_stb),
        .instr   (instr),
        .shut_q  (shut_q)
    );

    wiper_drive u_drive (
        .code_q (code_q),
        .shut_q (shut_q),
        .ladder (ladder)
    );

    assign tap_code = ladder.tap;
    assign open_a   = ladder.open_hi;
    assign short_wb = ladder.tie_lo;
    assign rd_value = code_q;
endmodule

// File: rtl/wiper_ctrl_checker.sv
module wiper_ctrl_checker
    import wiper_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cmd_stb,
    input logic              mid_rst,
    input logic              shut_req,
    input logic              data_stb,
    input logic [CODE_W-1:0] data_in,
    input logic [CODE_W-1:0] tap_code,
    input logic              open_a,
    input logic              short_wb,
    input logic [CODE_W-1:0] rd_value
);
    assert_reset_mid_R1: assert property (@(posedge clk)
        rst |=> (rd_value == midscale() && !open_a && !short_wb));

    assert_data_load_R2: assert property (@(posedge clk) disable iff (rst)
        (data_stb && !(cmd_stb && mid_rst)) |=> rd_value == $past(data_in));

    assert_mid_load_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb && mid_rst) |=> rd_value == midscale());

    assert_shut_follow_R4: assert property (@(posedge clk) disable iff (rst)
        cmd_stb |=> (open_a == $past(shut_req) && short_wb == $past(shut_req)));

    assert_shut_tap_R5: assert property (@(posedge clk) disable iff (rst)
        open_a |-> tap_code == '0);

    assert_run_tap_R11: assert property (@(posedge clk) disable iff (rst)
        !short_wb |-> tap_code == rd_value);

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!cmd_stb && !data_stb) |=> ($stable(rd_value) && $stable(open_a) && $stable(tap_code)));
endmodule

bind wiper_ctrl wiper_ctrl_checker u_wiper_ctrl_checker (.*);

// File: tb/wiper_ctrl_bench.sv
module wiper_ctrl_bench;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_stb = 1'b0, mid_rst = 1'b0, shut_req = 1'b0, data_stb = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic [7:0] tap_code, rd_value;
    logic       open_a, short_wb;

    int checks = 0;
    int fails  = 0;
    int m_code = 128;
    bit m_shut = 0;

    always #(PERIOD/2) clk = ~clk;

    wiper_ctrl u_wiper_ctrl (.*);

    task automatic check(input string tag);
        int exp_tap = m_shut ? 0 : m_code;
        checks++;
        if (rd_value !== 8'(m_code) || tap_code !== 8'(exp_tap) ||
            open_a !== m_shut || short_wb !== m_shut) begin
            fails++;
            $display("FAIL %s: rd=%0h tap=%0h oa=%0b sw=%0b expected rd=%0h tap=%0h oa/sw=%0b",
                     tag, rd_value, tap_code, open_a, short_wb, m_code, exp_tap, m_shut);
        end
    endtask

    task automatic step(input bit r, input bit c, input bit m, input bit s,
                        input bit d, input int v, input string tag);
        @(negedge clk);
        rst = r; cmd_stb = c; mid_rst = m; shut_req = s; data_stb = d; data_in = 8'(v);
        @(posedge clk);
        #1;
        if (r) begin
            m_code = 128; m_shut = 0;
        end else begin
            if (c && m) m_code = 128;
            else if (d) m_code = v;
            if (c) m_shut = s;
        end
        check(tag);
    endtask

    initial begin
        #(PERIOD * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        step(1, 0, 0, 0, 0, 0, "R1");
        step(1, 0, 0, 0, 0, 0, "R1");
        step(0, 0, 0, 0, 1, 8'h3C, "R2");
        step(0, 0, 1, 1, 0, 8'h55, "R9");
        step(0, 0, 0, 0, 0, 8'hAA, "R9");
        step(0, 1, 1, 0, 0, 0, "R3");
        step(0, 1, 0, 0, 0, 0, "R3");
        step(0, 0, 0, 0, 1, 8'h21, "R2");
        step(0, 1, 0, 1, 0, 0, "R4");
        step(0, 0, 0, 0, 0, 0, "R5");
        step(0, 0, 0, 0, 1, 8'h10, "R6");
        step(0, 0, 0, 0, 1, 8'hE7, "R6");
        step(0, 0, 0, 0, 0, 0, "R8");
        step(0, 1, 0, 0, 0, 0, "R6");
        step(0, 1, 1, 1, 0, 0, "R7");
        step(0, 1, 0, 0, 0, 0, "R7");
        step(0, 1, 1, 0, 1, 8'h44, "R10");
        step(0, 0, 0, 0, 1, 8'h00, "R11");
        step(0, 0, 0, 0, 1, 8'hFF, "R11");
        step(0, 0, 0, 0, 1, 8'h01, "R11");
        step(0, 1, 0, 1, 1, 8'h99, "R5");
        step(0, 1, 0, 0, 0, 0, "R4");
        for (int i = 0; i < 256; i += 17)
            step(0, 0, 0, 0, 1, i, "R11");
        step(1, 0, 0, 0, 0, 0, "R1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule